// File: doc/BRIEF.md
# Complex Window Multiplication Stage

This block sits in front of an in-place FFT engine and scales incoming complex samples by a real-valued window. Each beat carries four complex lanes. Every lane holds a half-precision real part and a half-precision imaginary part. The window coefficients live in a coefficient store that can be loaded at run time through a plain write port. The window shape can therefore change between transforms without rebuilding anything.

The FFT engine sends its raw input data through the stage with the multiply-mode flag high. Each lane's real and imaginary parts are then multiplied by that lane's coefficient, so each lane uses two multipliers and the stage uses eight. On later butterfly passes the engine drops the flag. The samples then pass through a bypass multiplexer unchanged. The bypass path has the same latency as the multiply path, so beats from either mode stay aligned in the stream.

The stage is a fixed pipeline of two registers. The coefficient read and the input capture happen in the first register. The products, or the bypassed samples, are registered in the second. There are no stalls, and output valid is simply input valid delayed by two cycles.

Top module: `cwin_stage`

## Requirements
- R1: While reset is held and in the cycles after its release in which no valid beat has yet been presented, `out_valid` is 0.
- R2: `out_valid` equals `in_valid` delayed by exactly two clock cycles. A beat presented before clock edge n appears at the outputs after edge n+1, with no gaps or merging for back-to-back beats.
- R3: When `in_first` is 0, `out_data` after two cycles is bit-identical to `in_data`. This holds for any code, including codes whose exponent field is all ones.
- R4: Coefficient address a is written with `cw_data` in the clock cycle in which `cw_en` is 1. The write applies to beats presented in later cycles. Lane k of a beat with index j (`in_beat` = j) is multiplied by the coefficient at address 4*j+k. The top index 1023 reaches address 4095.
- R5: In multiply mode, each lane's real part (bits 32k+15..32k) and imaginary part (bits 32k+31..32k+16) are each multiplied by the same lane coefficient. The half-precision code is sign bit 15, exponent bits 14..10 with bias 15, and fraction bits 9..0. The result sign is the XOR of the operand signs, and exact products are returned exactly.
- R6: An inexact product is rounded to the nearest representable value. An exact tie is rounded to the value with an even fraction field.
- R7: When rounding carries out of the fraction field, the exponent is incremented and the fraction becomes zero (for example, 0x3DA8 × 0x3DA8 gives 0x4000).
- R8: A product whose biased exponent would reach 31 or more saturates to 0x7BFF with the computed sign. No output of the multiply path has an all-ones exponent.
- R9: An operand with exponent field 0, or a product whose biased exponent would be 0 or less, gives a zero with the computed sign (0x0000 or 0x8000).
- R10: A coefficient of +0 (0x0000) or −0 (0x8000) gives a signed zero in both parts of the lane. The sign of that zero is the XOR of the sample sign and the coefficient sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_en | input | 1 | Coefficient write strobe |
| cw_addr | input | 12 | Coefficient write address (4*beat + lane) |
| cw_data | input | 16 | Coefficient value, half precision |
| in_valid | input | 1 | Input beat valid |
| in_first | input | 1 | 1 = multiply by window, 0 = bypass |
| in_beat | input | 10 | Beat index j used for coefficient lookup |
| in_data | input | 128 | Four complex lanes, lane k real at 32k+15..32k, imaginary at 32k+31..32k+16 |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 128 | Windowed or bypassed lanes, same layout as `in_data` |

## Verification
The bench builds the stage with its default parameters: four lanes and a 4096-entry coefficient space. This makes both the lowest beat index and the top index 1023 (addresses 4092 to 4095) reachable with directed writes. Hand-derived operand pairs place products exactly on rounding ties, on rounding carries into the exponent, just past the largest finite value, and just below the smallest normal value. A streaming run mixes multiply beats, bypass beats and an idle slot back to back. This exposes any latency mismatch between the two paths.

// File: rtl/cwin_pkg.sv
package cwin_pkg;
    localparam int HF_W      = 16;
    localparam int HF_EXP_W  = 5;
    localparam int HF_FRAC_W = 10;
    localparam int HF_BIAS   = 15;

    typedef logic [HF_W-1:0] hfloat_t;

    // Largest finite magnitude (sign bit excluded)
    localparam logic [HF_W-2:0] HF_MAX_MAG = 15'h7BFF;
endpackage

// File: rtl/cwin_coef_bank.sv
module cwin_coef_bank
    import cwin_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  hfloat_t       wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output hfloat_t       rd_data
);
    hfloat_t store [DEPTH];

    // Registered read; a same-cycle write to the same word returns old data.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= store[rd_addr];
        end
    end
endmodule

// File: rtl/cwin_hmul.sv
module cwin_hmul
    import cwin_pkg::*;
(
    input  hfloat_t op_a,
    input  hfloat_t op_b,
    output hfloat_t prod
);
    localparam int MW = HF_FRAC_W + 1;
    localparam int PW = 2 * MW;

    logic                 sgn;
    logic [MW-1:0]        man_a;
    logic [MW-1:0]        man_b;
    logic [PW-1:0]        raw;
    logic signed [7:0]    exp_s;
    logic [HF_FRAC_W-1:0] frac;
    logic                 guard_b;
    logic                 sticky_b;
    logic                 bump;
    logic [HF_FRAC_W:0]   frac_rnd;
    logic                 zero_in;

    always_comb begin
        sgn     = op_a[HF_W-1] ^ op_b[HF_W-1];
        zero_in = (op_a[14:10] == '0) || (op_b[14:10] == '0);
        man_a   = {1'b1, op_a[HF_FRAC_W-1:0]};
        man_b   = {1'b1, op_b[HF_FRAC_W-1:0]};
        raw     = {{MW{1'b0}}, man_a} * {{MW{1'b0}}, man_b};
        exp_s   = $signed({3'b000, op_a[14:10]}) + $signed({3'b000, op_b[14:10]})
                  - 8'(HF_BIAS);

        if (raw[PW-1]) begin
            frac     = raw[PW-2:PW-1-HF_FRAC_W];
            guard_b  = raw[PW-2-HF_FRAC_W];
            sticky_b = |raw[PW-3-HF_FRAC_W:0];
            exp_s    = exp_s + 8'sd1;
        end else begin
            frac     = raw[PW-3:PW-2-HF_FRAC_W];
            guard_b  = raw[PW-3-HF_FRAC_W];
            sticky_b = |raw[PW-4-HF_FRAC_W:0];
        end

        // Round to nearest, ties to even
        bump     = guard_b & (sticky_b | frac[0]);
        frac_rnd = {1'b0, frac} + {{HF_FRAC_W{1'b0}}, bump};
        if (frac_rnd[HF_FRAC_W]) begin
            exp_s = exp_s + 8'sd1;
        end

        if (zero_in) begin
            prod = {sgn, {(HF_W-1){1'b0}}};
        end else if (exp_s >= 8'sd31) begin
            prod = {sgn, HF_MAX_MAG};
        end else if (exp_s <= 8'sd0) begin
            prod = {sgn, {(HF_W-1){1'b0}}};
        end else begin
            prod = {sgn, exp_s[HF_EXP_W-1:0], frac_rnd[HF_FRAC_W-1:0]};
        end
    end
endmodule

// File: rtl/cwin_lane.sv
module cwin_lane
    import cwin_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    s1_valid,
    input  logic    s1_first,
    input  hfloat_t s1_re,
    input  hfloat_t s1_im,
    input  hfloat_t s1_coef,
    output hfloat_t out_re,
    output hfloat_t out_im
);
    hfloat_t mul_re;
    hfloat_t mul_im;
    logic    armed;

    cwin_hmul u_mul_re (.op_a(s1_re), .op_b(s1_coef), .prod(mul_re));
    cwin_hmul u_mul_im (.op_a(s1_im), .op_b(s1_coef), .prod(mul_im));

    // Bypass multiplexer in front of the output register
    always_ff @(posedge clk) begin
        if (s1_valid) begin
            out_re <= s1_first ? mul_re : s1_re;
            out_im <= s1_first ? mul_im : s1_im;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    p_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(s1_valid && s1_first) |->
            (out_re[15] == ($past(s1_re[15]) ^ $past(s1_coef[15]))) &&
            (out_im[15] == ($past(s1_im[15]) ^ $past(s1_coef[15]))));

    p_no_inf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(s1_valid && s1_first) |->
            (out_re[14:10] != 5'h1F) && (out_im[14:10] != 5'h1F));

    p_zero_coef_r10: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(s1_valid && s1_first && (s1_coef[14:10] == 5'h00)) |->
            (out_re[14:0] == 15'h0) && (out_im[14:0] == 15'h0));
endmodule

// File: rtl/cwin_stage.sv
module cwin_stage
    import cwin_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int MAX_LEN = 4096,
    parameter int ADDR_W  = $clog2(MAX_LEN),
    parameter int BEAT_W  = ADDR_W - $clog2(LANES),
    parameter int DW      = LANES * 2 * HF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_en,
    input  logic [ADDR_W-1:0] cw_addr,
    input  logic [HF_W-1:0]   cw_data,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic [BEAT_W-1:0] in_beat,
    input  logic [DW-1:0]     in_data,
    output logic              out_valid,
    output logic [DW-1:0]     out_data
);
    localparam int LANE_W     = $clog2(LANES);
    localparam int BANK_DEPTH = MAX_LEN / LANES;
    localparam int SLOT_W     = 2 * HF_W;

    logic          s1_valid;
    logic          s1_first;
    logic [DW-1:0] s1_data;
    logic [1:0]    warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            s1_valid  <= in_valid;
            out_valid <= s1_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid) begin
            s1_first <= in_first;
            s1_data  <= in_data;
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        hfloat_t coef_q;
        hfloat_t lane_re;
        hfloat_t lane_im;
        logic    bank_we;

        assign bank_we = cw_en && (cw_addr[LANE_W-1:0] == LANE_W'(k));

        cwin_coef_bank #(.DEPTH(BANK_DEPTH), .AW(BEAT_W)) u_bank (
            .clk     (clk),
            .wr_en   (bank_we),
            .wr_addr (cw_addr[ADDR_W-1:LANE_W]),
            .wr_data (cw_data),
            .rd_en   (in_valid),
            .rd_addr (in_beat),
            .rd_data (coef_q)
        );

        cwin_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .s1_valid (s1_valid),
            .s1_first (s1_first),
            .s1_re    (s1_data[k*SLOT_W +: HF_W]),
            .s1_im    (s1_data[k*SLOT_W+HF_W +: HF_W]),
            .s1_coef  (coef_q),
            .out_re   (lane_re),
            .out_im   (lane_im)
        );

        assign out_data[k*SLOT_W +: HF_W]      = lane_re;
        assign out_data[k*SLOT_W+HF_W +: HF_W] = lane_im;
    end

    // Cycles since reset, saturating at 2, for history-based checks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm <= 2'd0;
        end else if (warm != 2'd2) begin
            warm <= warm + 2'd1;
        end
    end

    p_valid_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    p_bypass_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) && $past(in_valid, 2) && !$past(in_first, 2) |->
            (out_data == $past(in_data, 2)));

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd0) |-> !out_valid);
endmodule

// File: tb/cwin_stage_test.sv
module cwin_stage_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cw_en = 1'b0;
    logic [11:0]  cw_addr = '0;
    logic [15:0]  cw_data = '0;
    logic         in_valid = 1'b0;
    logic         in_first = 1'b0;
    logic [9:0]   in_beat = '0;
    logic [127:0] in_data = '0;
    logic         out_valid;
    logic [127:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cwin_stage uut (
        .clk(clk), .rst_n(rst_n), .cw_en(cw_en), .cw_addr(cw_addr),
        .cw_data(cw_data), .in_valid(in_valid), .in_first(in_first),
        .in_beat(in_beat), .in_data(in_data), .out_valid(out_valid),
        .out_data(out_data)
    );

    function automatic logic [127:0] pk(input logic [15:0] r0, i0, r1, i1,
                                        r2, i2, r3, i3);
        return {i3, r3, i2, r2, i1, r1, i0, r0};
    endfunction

    function automatic logic [127:0] rep(input logic [15:0] re, im);
        return pk(re, im, re, im, re, im, re, im);
    endfunction

    task automatic chk(input string req, input logic [127:0] got, exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr_coef(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        cw_en = 1'b1; cw_addr = a; cw_data = d;
        @(negedge clk);
        cw_en = 1'b0;
    endtask

    task automatic wr_beat(input logic [9:0] j, input logic [15:0] c0, c1, c2, c3);
        wr_coef({j, 2'd0}, c0);
        wr_coef({j, 2'd1}, c1);
        wr_coef({j, 2'd2}, c2);
        wr_coef({j, 2'd3}, c3);
    endtask

    // One isolated beat, result sampled at the negedge after the second edge
    task automatic run_beat(input string req, input logic [9:0] j, input logic first,
                            input logic [127:0] din, exp);
        @(negedge clk);
        in_valid = 1'b1; in_first = first; in_beat = j; in_data = din;
        @(negedge clk);
        in_valid = 1'b0; in_data = '0;
        chk("R2 valid not early", {127'd0, out_valid}, 128'd0);
        @(negedge clk);
        chk("R2 valid at latency", {127'd0, out_valid}, 128'd1);
        chk(req, out_data, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 valid in reset", {127'd0, out_valid}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 valid idle after reset", {127'd0, out_valid}, 128'd0);
    endtask

    task automatic t_bypass;
        run_beat("R3 bypass codes", 10'd7, 1'b0,
                 pk(16'h7C00, 16'hFFFF, 16'h0001, 16'h8000,
                    16'h3DA8, 16'h7BFF, 16'hC200, 16'h1234), 
                 pk(16'h7C00, 16'hFFFF, 16'h0001, 16'h8000,
                    16'h3DA8, 16'h7BFF, 16'hC200, 16'h1234));
    endtask

    task automatic t_addressing;
        wr_beat(10'd5, 16'h3C00, 16'h4000, 16'h3800, 16'hBC00);
        run_beat("R4 R5 beat 5 lanes", 10'd5, 1'b1, rep(16'h4200, 16'hC000),
                 pk(16'h4200, 16'hC000, 16'h4600, 16'hC400,
                    16'h3E00, 16'hBC00, 16'hC200, 16'h4000));
        wr_beat(10'd1023, 16'h3800, 16'h4000, 16'hB800, 16'h4400);
        run_beat("R4 top index 1023", 10'd1023, 1'b1, rep(16'h4000, 16'h3C00),
                 pk(16'h3C00, 16'h3800, 16'h4400, 16'h4000,
                    16'hBC00, 16'hB800, 16'h4800, 16'h4400));
    endtask

    task automatic t_rounding;
        wr_beat(10'd2, 16'h3C01, 16'h3C03, 16'h3DA8, 16'h3C01);
        run_beat("R6 R7 rounding", 10'd2, 1'b1,
                 pk(16'h3E00, 16'h3C01, 16'h3E00, 16'hBE00,
                    16'h3DA8, 16'hBDA8, 16'h3FFF, 16'h3C00),
                 pk(16'h3E02, 16'h3C02, 16'h3E04, 16'hBE04,
                    16'h4000, 16'hC000, 16'h4000, 16'h3C01));
    endtask

    task automatic t_saturate;
        wr_beat(10'd3, 16'h4000, 16'h4000, 16'h4000, 16'h4000);
        run_beat("R8 saturation", 10'd3, 1'b1,
                 pk(16'h7800, 16'hF800, 16'h7BFF, 16'h3C00,
                    16'h5000, 16'h7400, 16'h77FF, 16'h0000),
                 pk(16'h7BFF, 16'hFBFF, 16'h7BFF, 16'h4000,
                    16'h5400, 16'h7800, 16'h7BFF, 16'h0000));
    endtask

    task automatic t_flush;
        wr_beat(10'd4, 16'h3800, 16'h3800, 16'h3800, 16'h3800);
        run_beat("R9 flush to zero", 10'd4, 1'b1,
                 pk(16'h0400, 16'h8400, 16'h0800, 16'h0001,
                    16'h83FF, 16'h3C00, 16'h0401, 16'hC400),
                 pk(16'h0000, 16'h8000, 16'h0400, 16'h0000,
                    16'h8000, 16'h3800, 16'h0000, 16'hC000));
    endtask

    task automatic t_zero_coef;
        wr_beat(10'd6, 16'h0000, 16'h8000, 16'h0000, 16'h8000);
        run_beat("R10 signed zero", 10'd6, 1'b1, rep(16'h4200, 16'hC200),
                 pk(16'h0000, 16'h8000, 16'h8000, 16'h0000,
                    16'h0000, 16'h8000, 16'h8000, 16'h0000));
    endtask

    task automatic t_rewrite;
        wr_coef({10'd5, 2'd0}, 16'h4400);
        run_beat("R4 rewrite at run time", 10'd5, 1'b1, rep(16'h3C00, 16'h3C00),
                 pk(16'h4400, 16'h4400, 16'h4000, 16'h4000,
                    16'h3800, 16'h3800, 16'hBC00, 16'hBC00));
    endtask

    task automatic t_stream;
        logic [127:0] din  [4];
        logic [127:0] dexp [4];
        logic         vld  [4];
        logic         fst  [4];
        logic [9:0]   bt   [4];
        din[0] = rep(16'h3C00, 16'hBC00); fst[0] = 1; bt[0] = 10'd5; vld[0] = 1;
        dexp[0] = pk(16'h4400, 16'hC400, 16'h4000, 16'hC000,
                     16'h3800, 16'hB800, 16'hBC00, 16'h3C00);
        din[1] = rep(16'h7E00, 16'h0003); fst[1] = 0; bt[1] = 10'd5; vld[1] = 1;
        dexp[1] = din[1];
        din[2] = rep(16'h3C00, 16'h3C00); fst[2] = 1; bt[2] = 10'd3; vld[2] = 0;
        dexp[2] = '0;
        din[3] = rep(16'h3C00, 16'h4200); fst[3] = 1; bt[3] = 10'd3; vld[3] = 1;
        dexp[3] = rep(16'h4000, 16'h4600);
        for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            if (n >= 2) begin
                chk("R2 stream valid", {127'd0, out_valid}, {127'd0, vld[n-2]});
                if (vld[n-2]) begin
                    chk("R3 R5 stream data", out_data, dexp[n-2]);
                end
            end
            if (n < 4) begin
                in_valid = vld[n]; in_first = fst[n]; in_beat = bt[n]; in_data = din[n];
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    initial begin
        t_reset();
        t_bypass();
        t_addressing();
        t_rounding();
        t_saturate();
        t_flush();
        t_zero_coef();
        t_rewrite();
        t_stream();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule